// File: doc/BRIEF.md
# Security Register Erase Sequencer

This block sits behind the command decoder of a serial flash slave and handles erasing its one-time-programmable security registers. The decoder hands it every opcode byte together with a strobe that marks a complete 8-bit byte. It also sends a pulse when chip select returns high. The block keeps three status bits that a status read path can expose: the write-enable latch, the busy (write-in-progress) flag and the permanent lock bit.

A write-enable frame with opcode 0x06 arms the latch. An erase frame with opcode 0x44 carries exactly one byte and ends right after it. When it arrives with the latch armed, no erase running and the lock clear, the block sends a one-cycle start pulse to the array and names the register to clear. The register number is one of four 256-byte registers, picked by a select input. The block then holds the busy flag for a fixed number of clock cycles set by a parameter. This count stands in for the self-timed erase. Once the lock bit has been set, every later erase request is dropped without effect.

Top module: `secreg_erase_ctrl`

## Requirements
- R1: After reset, wel, wip, lock and erase_start are all 0.
- R2: A frame holding exactly one byte 0x06 and then a cs_rise pulse, with wip at 0, sets wel in the cycle after the cs_rise.
- R3: A frame holding exactly one byte 0x44 and then cs_rise, with wel=1, wip=0 and lock=0, drives erase_start high for exactly one cycle, in the cycle after cs_rise. In that cycle erase_sel equals the reg_sel value sampled with cs_rise.
- R4: In the cycle where an accepted erase starts, wip reads 1 and wel reads 0.
- R5: After an accepted erase, wip stays 1 for exactly ERASE_CYCLES cycles and then returns to 0.
- R6: An erase frame that ends with zero bytes, or with more than one byte, received is discarded: there is no start and wel keeps its value.
- R7: An erase frame that arrives while wel is 0 causes no start.
- R8: A lock_req pulse sets lock in the next cycle. Only reset clears lock again. While lock is 1, erase frames cause no start and leave wel unchanged.
- R9: While wip is 1, both 0x06 and 0x44 frames are ignored: wel does not change and no start is issued.
- R10: When lock_req and the cs_rise that ends a valid erase frame arrive in the same cycle, the lock wins: there is no start, wel stays 1 and lock becomes 1.
- R11: A byte strobe in the same cycle as cs_rise is not counted in the frame that is ending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_vld | input | 1 | One-cycle strobe: byte_in holds a complete received byte |
| byte_in | input | 8 | Received byte |
| cs_rise | input | 1 | One-cycle pulse: chip select returned high, so the frame has ended |
| reg_sel | input | SEL_W | Security register to erase, sampled with cs_rise |
| lock_req | input | 1 | One-cycle request to set the permanent lock bit |
| wel | output | 1 | Write-enable latch |
| wip | output | 1 | Erase in progress |
| lock | output | 1 | Permanent lock bit |
| erase_start | output | 1 | One-cycle start pulse to the array |
| erase_sel | output | SEL_W | Register being erased, valid with erase_start |

## Verification
The two functions that can land in the same clock cycle are the lock request and the end of an erase frame that would otherwise be accepted. The bench arms the latch, sends the single 0x44 byte, then pulses lock_req on the same cycle as cs_rise. The expected result is no start pulse, wel still set and lock set. A second clash puts a byte strobe on the same cycle as cs_rise, and that byte must not stop a one-byte erase frame from being accepted. A behavioural model in the bench judges both clashes cycle by cycle.

// File: rtl/secreg_pkg.sv
package secreg_pkg;

  localparam logic [7:0] OP_WREN     = 8'h06;
  localparam logic [7:0] OP_SEC_ERASE = 8'h44;

  typedef enum logic [1:0] {
    FL_EMPTY = 2'd0,
    FL_ONE   = 2'd1,
    FL_MANY  = 2'd2
  } frame_len_t;

  typedef struct packed {
    logic arm_wel;
    logic go_erase;
  } cmd_act_t;

endpackage

// File: rtl/secreg_frame_tracker.sv
module secreg_frame_tracker
  import secreg_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              frame_end,
  output frame_len_t        len,
  output logic [BYTE_W-1:0] opcode
);

  frame_len_t        len_d;
  logic [BYTE_W-1:0] op_d;
  logic              op_en;

  // frame end wins over a coincident byte strobe
  always_comb begin
    len_d = len;
    op_d  = opcode;
    op_en = 1'b0;
    if (frame_end) begin
      len_d = FL_EMPTY;
    end else if (byte_vld) begin
      unique case (len)
        FL_EMPTY: begin
          len_d = FL_ONE;
          op_d  = byte_in;
          op_en = 1'b1;
        end
        FL_ONE:  len_d = FL_MANY;
        default: len_d = FL_MANY;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len    <= FL_EMPTY;
      opcode <= '0;
    end else begin
      len <= len_d;
      if (op_en) opcode <= op_d;
    end
  end

endmodule

// File: rtl/secreg_cmd_decide.sv
module secreg_cmd_decide
  import secreg_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  frame_len_t        len,
  input  logic [BYTE_W-1:0] opcode,
  input  logic              frame_end,
  input  logic              wel,
  input  logic              busy,
  input  logic              lock,
  input  logic              lock_req,
  output cmd_act_t          act
);

  logic single_byte;
  logic is_wren;
  logic is_erase;

  always_comb begin
    single_byte  = frame_end && (len == FL_ONE) && !busy;
    is_wren      = (opcode == BYTE_W'(OP_WREN));
    is_erase     = (opcode == BYTE_W'(OP_SEC_ERASE));
    act.arm_wel  = single_byte && is_wren;
    act.go_erase = single_byte && is_erase && wel && !lock && !lock_req;
  end

endmodule

// File: rtl/secreg_erase_timer.sv
module secreg_erase_timer #(
  parameter int CYCLES = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic busy
);

  localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LOAD_VAL = CW'(CYCLES - 1);

  logic [CW-1:0] cnt, cnt_d;
  logic          busy_d;
  logic          cnt_en;

  always_comb begin
    cnt_d  = cnt;
    busy_d = busy;
    cnt_en = 1'b0;
    if (load) begin
      cnt_d  = LOAD_VAL;
      busy_d = 1'b1;
      cnt_en = 1'b1;
    end else if (busy) begin
      if (cnt == '0) begin
        busy_d = 1'b0;
      end else begin
        cnt_d  = cnt - 1'b1;
        cnt_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      busy <= 1'b0;
    end else begin
      busy <= busy_d;
      if (cnt_en) cnt <= cnt_d;
    end
  end

endmodule

// File: rtl/secreg_status_regs.sv
module secreg_status_regs
  import secreg_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cmd_act_t         act,
  input  logic             lock_req,
  input  logic [SEL_W-1:0] sel_in,
  output logic             wel,
  output logic             lock,
  output logic             start,
  output logic [SEL_W-1:0] sel_q
);

  logic wel_d, lock_d;

  always_comb begin
    wel_d  = wel;
    lock_d = lock | lock_req;
    if (act.go_erase)     wel_d = 1'b0;
    else if (act.arm_wel) wel_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel   <= 1'b0;
      lock  <= 1'b0;
      start <= 1'b0;
      sel_q <= '0;
    end else begin
      wel   <= wel_d;
      lock  <= lock_d;
      start <= act.go_erase;
      if (act.go_erase) sel_q <= sel_in;
    end
  end

endmodule

// File: rtl/secreg_erase_ctrl.sv
module secreg_erase_ctrl
  import secreg_pkg::*;
#(
  parameter int NUM_REGS     = 4,
  parameter int ERASE_CYCLES = 40,
  localparam int SEL_W       = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_vld,
  input  logic [7:0]       byte_in,
  input  logic             cs_rise,
  input  logic [SEL_W-1:0] reg_sel,
  input  logic             lock_req,
  output logic             wel,
  output logic             wip,
  output logic             lock,
  output logic             erase_start,
  output logic [SEL_W-1:0] erase_sel
);

  frame_len_t len;
  logic [7:0] opcode;
  cmd_act_t   act;

  secreg_frame_tracker #(.BYTE_W(8)) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_vld  (byte_vld),
    .byte_in   (byte_in),
    .frame_end (cs_rise),
    .len       (len),
    .opcode    (opcode)
  );

  secreg_cmd_decide #(.BYTE_W(8)) u_decide (
    .len       (len),
    .opcode    (opcode),
    .frame_end (cs_rise),
    .wel       (wel),
    .busy      (wip),
    .lock      (lock),
    .lock_req  (lock_req),
    .act       (act)
  );

  secreg_erase_timer #(.CYCLES(ERASE_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (act.go_erase),
    .busy  (wip)
  );

  secreg_status_regs #(.SEL_W(SEL_W)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .act      (act),
    .lock_req (lock_req),
    .sel_in   (reg_sel),
    .wel      (wel),
    .lock     (lock),
    .start    (erase_start),
    .sel_q    (erase_sel)
  );

endmodule

// File: rtl/secreg_erase_chk.sv
module secreg_erase_chk #(
  parameter int ERASE_CYCLES = 40
) (
  input logic clk,
  input logic rst_n,
  input logic cs_rise,
  input logic lock_req,
  input logic wel,
  input logic wip,
  input logic lock,
  input logic erase_start
);

  int unsigned busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   busy_run <= 0;
    else if (wip) busy_run <= busy_run + 1;
    else          busy_run <= 0;
  end

  p_start_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |=> !erase_start);

  p_start_after_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |-> $past(cs_rise));

  p_start_needs_wel_r7: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |-> $past(wel) && !$past(wip));

  p_wel_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |-> wip && !wel);

  p_busy_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip) |-> erase_start);

  p_busy_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wip) |-> busy_run == ERASE_CYCLES);

  p_lock_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lock) |-> lock);

  p_locked_no_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |-> !$past(lock) && !$past(lock_req));

endmodule

bind secreg_erase_ctrl secreg_erase_chk #(.ERASE_CYCLES(ERASE_CYCLES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cs_rise     (cs_rise),
  .lock_req    (lock_req),
  .wel         (wel),
  .wip         (wip),
  .lock        (lock),
  .erase_start (erase_start)
);

// File: tb/sim_secreg_erase_ctrl.sv
`timescale 1ns/1ps
module sim_secreg_erase_ctrl;

  localparam int N = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       byte_vld = 1'b0;
  logic [7:0] byte_in = 8'h00;
  logic       cs_rise = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic       lock_req = 1'b0;
  logic       wel, wip, lock, erase_start;
  logic [1:0] erase_sel;

  always #5 clk = ~clk;

  secreg_erase_ctrl #(.NUM_REGS(4), .ERASE_CYCLES(N)) u0 (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_in(byte_in),
    .cs_rise(cs_rise), .reg_sel(reg_sel), .lock_req(lock_req),
    .wel(wel), .wip(wip), .lock(lock), .erase_start(erase_start),
    .erase_sel(erase_sel)
  );

  // behavioural reference
  int m_bytes, m_op, m_wel, m_wip, m_left, m_lock, m_start, m_sel;
  int compared = 0, mismatched = 0, cycles = 0;
  string cur_req = "R1";

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_bytes = 0; m_op = 0; m_wel = 0; m_wip = 0;
      m_left = 0; m_lock = 0; m_start = 0; m_sel = 0;
    end else begin
      automatic int was_busy = m_wip;
      m_start = 0;
      if (cs_rise) begin
        if (m_bytes == 1 && !was_busy) begin
          if (m_op == 8'h06) m_wel = 1;
          if (m_op == 8'h44 && m_wel == 1 && !m_lock && !lock_req) begin
            m_start = 1; m_sel = reg_sel; m_wel = 0; m_wip = 1; m_left = N;
          end
        end
        m_bytes = 0;
      end else if (byte_vld) begin
        if (m_bytes == 0) m_op = byte_in;
        if (m_bytes < 2) m_bytes++;
      end
      if (lock_req) m_lock = 1;
      if (was_busy) begin
        if (m_left == 1) m_wip = 0;
        else m_left--;
      end
    end
  end

  task automatic cmp(input string nm, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL [%s] %s actual %0d expected %0d at cycle %0d", cur_req, nm, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      cmp("wel", wel, m_wel);
      cmp("wip", wip, m_wip);
      cmp("lock", lock, m_lock);
      cmp("erase_start", erase_start, m_start);
      if (m_start == 1) cmp("erase_sel", erase_sel, m_sel);
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // nb bytes: first is op, rest filler; then cs_rise (optionally with a byte / lock)
  task automatic frame(input logic [7:0] op, input int nb, input logic [1:0] s,
                       input logic end_byte, input logic end_lock);
    for (int i = 0; i < nb; i++) begin
      @(negedge clk);
      byte_vld = 1'b1; byte_in = (i == 0) ? op : 8'hA5;
    end
    @(negedge clk);
    byte_vld = end_byte; byte_in = 8'h5A;
    cs_rise = 1'b1; reg_sel = s; lock_req = end_lock;
    @(negedge clk);
    byte_vld = 1'b0; cs_rise = 1'b0; lock_req = 1'b0; reg_sel = 2'd0;
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    cur_req = "R1"; idle(3);
    if (wel || wip || lock || erase_start) begin
      mismatched++; $display("FAIL [R1] reset state actual %b%b%b%b expected 0000", wel, wip, lock, erase_start);
    end
    compared++;
    cur_req = "R7"; frame(8'h44, 1, 2'd1, 1'b0, 1'b0); idle(3);
    cur_req = "R2"; frame(8'h06, 1, 2'd0, 1'b0, 1'b0); idle(2);
    cur_req = "R6"; frame(8'h44, 2, 2'd1, 1'b0, 1'b0); idle(2);
    frame(8'h44, 0, 2'd1, 1'b0, 1'b0); idle(2);
    frame(8'h44, 3, 2'd1, 1'b0, 1'b0); idle(2);
    cur_req = "R3"; frame(8'h44, 1, 2'd2, 1'b0, 1'b0);
    cur_req = "R9"; frame(8'h06, 1, 2'd0, 1'b0, 1'b0);
    frame(8'h44, 1, 2'd3, 1'b0, 1'b0);
    cur_req = "R5"; idle(N + 4);
    cur_req = "R4"; frame(8'h06, 1, 2'd0, 1'b0, 1'b0);
    cur_req = "R11"; frame(8'h44, 1, 2'd3, 1'b1, 1'b0);
    idle(N + 4);
    cur_req = "R10"; frame(8'h06, 1, 2'd0, 1'b0, 1'b0);
    frame(8'h44, 1, 2'd1, 1'b0, 1'b1); idle(3);
    cur_req = "R8"; frame(8'h06, 1, 2'd0, 1'b0, 1'b0);
    frame(8'h44, 1, 2'd0, 1'b0, 1'b0); idle(3);
    @(negedge clk); lock_req = 1'b1; @(negedge clk); lock_req = 1'b0;
    idle(5);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #1000000;
    mismatched++;
    $display("FAIL [watchdog] run actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule